// File: doc/BRIEF.md
# E1 Frame Alignment Searcher

This block locks onto the 256-bit frame structure of a serial E1 stream. One bit comes in per clock in which `bit_vld` is high. A seven-bit history window slides along the stream until it meets the alignment word. A small state machine then tests the byte at the same offset in the frames that follow:

- The next frame must carry the non-alignment marker.
- The frame after that must carry the alignment word again.

When a test fails, the search restarts bit by bit.

There are two recovery policies:

- **Policy 0:** the hunt resumes with the very next bit.
- **Policy 1:** after a failed marker test, the block skips one whole frame before hunting again. A payload timeslot that always imitates the alignment word therefore cannot hold the block in a loop.

An optional confirmation stage asks for one more marker frame and one more alignment frame before lock is declared.

Once locked, the block reports three things: a sticky in-frame flag, a one-cycle frame-start strobe on the first bit of each timeslot 0, and the position of each accepted bit within the frame. It is meant to sit after line decoding. Its results feed multiframe and payload logic further down the path.

Top module: `e1_frame_align`

## Requirements
- R1: Bits are numbered 1 to 8 within timeslot 0, and bit 1 is received first. A frame is 256 bits. While searching, every accepted bit is tested as a possible bit 8. A candidate exists when bits 2..8 equal 0011011.
- R2: After a candidate, the byte at the same offset one frame later must have bit 2 equal to 1, or the check fails.
- R3: One frame after a passed bit-2 check, bits 2..8 at the same offset must again equal 0011011, or the check fails and bit-by-bit search resumes after that byte.
- R4: With `alg_sel`=0, a failed bit-2 check resumes bit-by-bit search starting with the bit that follows the failing byte.
- R5: With `alg_sel`=1, a failed bit-2 check makes the block wait one frame. It ignores whatever the assumed timeslot 0 of that frame holds, and resumes searching after it. A failed alignment-word check resumes search immediately under either policy.
- R6: With `chk_en`=1, two further frames must pass, first bit 2 = 1 and then 0011011, before lock. With `chk_en`=0, lock follows the third-frame check directly.
- R7: During the confirmation stage, a failed bit-2 check follows the policy of R4/R5. A failed alignment-word check returns to search.
- R8: `alg_sel` and `chk_en` are captured only while searching. Changes made during the checking frames have no effect until search resumes.
- R9: `in_frame` rises on the clock that accepts bit 8 of the confirming timeslot 0. It then stays high until reset.
- R10: `bit_pos` gives the position (0..255) of the last accepted bit, where 0 is bit 1 of timeslot 0 once aligned. While locked, `frame_start` is high for exactly the cycle after bit 1 of timeslot 0 is accepted, together with `bit_pos`=0.
- R11: When `bit_vld` is low, no bit is consumed and `bit_pos` holds.
- R12: Synchronous reset clears `in_frame`, `frame_start` and `bit_pos` to 0 and returns the block to searching.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | `bit_in` carries a line bit this cycle |
| bit_in | input | 1 | Serial E1 data |
| alg_sel | input | 1 | Recovery policy: 0 immediate, 1 one-frame hold-off |
| chk_en | input | 1 | Enable the two-frame confirmation |
| in_frame | output | 1 | Alignment declared |
| frame_start | output | 1 | Strobe on bit 1 of an aligned timeslot 0 |
| bit_pos | output | 8 | Position of the last accepted bit within the frame |

## Verification
The following properties are checked on every cycle:
- lock can only be entered from the third-frame check with confirmation disabled, or from the end of the confirmation stage;
- lock never drops;
- the hold-off state is reached only under policy 1 and always leads back to search;
- the captured configuration stays frozen across the checking frames;
- the strobe appears only while locked and at position 0;
- the position holds when no bit arrives.

The bench scenarios show the rest, because the exact frame in which lock appears depends on the stream history. These cover:
- how many frames each pass and fail pattern takes, per policy and with confirmation on or off;
- that a genuine alignment word is skipped during the hold-off;
- that configuration changes during checking are ignored.

// File: rtl/e1fa_pkg.sv
package e1fa_pkg;

  typedef enum logic [2:0] {
    ST_SEARCH  = 3'd0,
    ST_NFAS1   = 3'd1,
    ST_FAS3    = 3'd2,
    ST_HOLD    = 3'd3,
    ST_CS_NFAS = 3'd4,
    ST_CS_FAS  = 3'd5,
    ST_LOCK    = 3'd6
  } fa_state_e;

  // bits 2..8 of the alignment byte, bit 2 in the MSB
  localparam logic [6:0] ALIGN_WORD = 7'b0011011;

endpackage

// File: rtl/e1fa_window.sv
module e1fa_window #(
  parameter int          TS_BITS = 8,
  parameter logic [6:0]  PATTERN = e1fa_pkg::ALIGN_WORD
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic bit_in,
  output logic word_hit,
  output logic mark_hit
);

  localparam int HW = TS_BITS - 1;

  logic [HW-1:0] hist;
  logic [HW:0]   win;

  // win[HW] is the oldest bit (bit 1), win[0] the bit arriving now
  assign win      = {hist, bit_in};
  assign word_hit = (win[HW-1:0] == PATTERN);
  assign mark_hit = win[HW-1];

  always_ff @(posedge clk) begin
    if (rst)          hist <= '1;
    else if (bit_vld) hist <= win[HW-1:0];
  end

endmodule

// File: rtl/e1fa_bitpos.sv
module e1fa_bitpos #(
  parameter int FRAME_BITS = 256,
  parameter int LOAD_POS   = 7,
  parameter int EVAL_POS   = 7,
  localparam int POS_W     = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_vld,
  input  logic             load,
  output logic [POS_W-1:0] pos,
  output logic             eval_now,
  output logic             wrap_now
);

  logic [POS_W-1:0] nxt;

  always_comb begin
    if (pos == POS_W'(FRAME_BITS - 1)) nxt = '0;
    else                               nxt = pos + 1'b1;
  end

  assign eval_now = (nxt == POS_W'(EVAL_POS));
  assign wrap_now = (nxt == '0);

  always_ff @(posedge clk) begin
    if (rst)          pos <= '0;
    else if (bit_vld) pos <= load ? POS_W'(LOAD_POS) : nxt;
  end

  AST_POS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bit_vld)) |-> $stable(pos)); // R11

endmodule

// File: rtl/e1fa_ctrl.sv
module e1fa_ctrl
  import e1fa_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic word_hit,
  input  logic mark_hit,
  input  logic eval_now,
  input  logic wrap_now,
  input  logic alg_sel,
  input  logic chk_en,
  output logic load_pos,
  output logic in_frame,
  output logic frame_start
);

  fa_state_e st, st_nxt;
  logic      alg_q, chk_q;
  fa_state_e mark_fail;

  assign mark_fail = alg_q ? ST_HOLD : ST_SEARCH;
  assign load_pos  = (st == ST_SEARCH) && word_hit;

  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_SEARCH:  if (word_hit) st_nxt = ST_NFAS1;
      ST_NFAS1:   if (eval_now) st_nxt = mark_hit ? ST_FAS3 : mark_fail;
      ST_FAS3:    if (eval_now) st_nxt = word_hit ? (chk_q ? ST_CS_NFAS : ST_LOCK) : ST_SEARCH;
      ST_HOLD:    if (eval_now) st_nxt = ST_SEARCH;
      ST_CS_NFAS: if (eval_now) st_nxt = mark_hit ? ST_CS_FAS : mark_fail;
      ST_CS_FAS:  if (eval_now) st_nxt = word_hit ? ST_LOCK : ST_SEARCH;
      ST_LOCK:    st_nxt = ST_LOCK;
      default:    st_nxt = ST_SEARCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_SEARCH;
      alg_q       <= 1'b0;
      chk_q       <= 1'b0;
      in_frame    <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      if (st == ST_SEARCH) begin
        alg_q <= alg_sel;
        chk_q <= chk_en;
      end
      if (bit_vld) begin
        st       <= st_nxt;
        in_frame <= (st_nxt == ST_LOCK);
      end
      frame_start <= bit_vld && (st == ST_LOCK) && wrap_now;
    end
  end

  AST_LOCK_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(in_frame) |-> (($past(st) == ST_CS_FAS) ||
                         ($past(st) == ST_FAS3 && !$past(chk_q)))); // R6
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    in_frame |=> in_frame); // R9
  AST_HOLD_POLICY: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HOLD) |-> alg_q); // R5
  AST_HOLD_EXIT: assert property (@(posedge clk) disable iff (rst)
    ($past(st) == ST_HOLD && st != ST_HOLD) |-> (st == ST_SEARCH)); // R5
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (st != ST_SEARCH && $past(st) != ST_SEARCH) |-> ($stable(alg_q) && $stable(chk_q))); // R8
  AST_STROBE_LOCKED: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> in_frame); // R10

endmodule

// File: rtl/e1_frame_align.sv
module e1_frame_align #(
  parameter int FRAME_BITS = 256,
  parameter int TS_BITS    = 8,
  localparam int POS_W     = $clog2(FRAME_BITS),
  localparam int BYTE_END  = TS_BITS - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic             alg_sel,
  input  logic             chk_en,
  output logic             in_frame,
  output logic             frame_start,
  output logic [POS_W-1:0] bit_pos
);

  logic word_hit, mark_hit, eval_now, wrap_now, load_pos;

  e1fa_window #(.TS_BITS(TS_BITS)) u_window (
    .clk      (clk),
    .rst      (rst),
    .bit_vld  (bit_vld),
    .bit_in   (bit_in),
    .word_hit (word_hit),
    .mark_hit (mark_hit)
  );

  e1fa_bitpos #(
    .FRAME_BITS (FRAME_BITS),
    .LOAD_POS   (BYTE_END),
    .EVAL_POS   (BYTE_END)
  ) u_bitpos (
    .clk      (clk),
    .rst      (rst),
    .bit_vld  (bit_vld),
    .load     (load_pos),
    .pos      (bit_pos),
    .eval_now (eval_now),
    .wrap_now (wrap_now)
  );

  e1fa_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .bit_vld     (bit_vld),
    .word_hit    (word_hit),
    .mark_hit    (mark_hit),
    .eval_now    (eval_now),
    .wrap_now    (wrap_now),
    .alg_sel     (alg_sel),
    .chk_en      (chk_en),
    .load_pos    (load_pos),
    .in_frame    (in_frame),
    .frame_start (frame_start)
  );

  AST_STROBE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (bit_pos == '0)); // R10

endmodule

// File: tb/e1_frame_align_bench.sv
`timescale 1ns/100ps
module e1_frame_align_bench;

  logic       clk = 1'b0;
  logic       rst, bit_vld, bit_in, alg_sel, chk_en;
  logic       in_frame, frame_start;
  logic [7:0] bit_pos;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  e1_frame_align u_e1_frame_align (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
    .alg_sel(alg_sel), .chk_en(chk_en),
    .in_frame(in_frame), .frame_start(frame_start), .bit_pos(bit_pos)
  );

  // frame kinds: 0 align word, 1 marker bit2=1, 2 bad marker, 3 no word
  typedef struct packed {
    logic        alg;
    logic        chk;
    logic [47:0] seq;
    logic [11:0] exp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 48'h010101010101, 12'b001111111111},
    '{1'b0, 1'b1, 48'h010101010101, 12'b000011111111},
    '{1'b0, 1'b0, 48'h020101010101, 12'b000011111111},
    '{1'b1, 1'b0, 48'h020101010101, 12'b000000111111},
    '{1'b0, 1'b0, 48'h013010101010, 12'b000001111111},
    '{1'b1, 1'b0, 48'h013010101010, 12'b000001111111},
    '{1'b0, 1'b1, 48'h010201010101, 12'b000000001111},
    '{1'b1, 1'b1, 48'h010201010101, 12'b000000000011},
    '{1'b0, 1'b1, 48'h010130101010, 12'b000000000111}
  };

  function automatic string vec_tag(input int v);
    case (v)
      0:       return "R1 R2 R3 R9";
      1:       return "R6";
      2:       return "R4";
      3:       return "R5";
      4:       return "R3 R4";
      5:       return "R5 fas-fail";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [7:0] ts0_of(input int k);
    case (k)
      0:       return 8'h1B;
      1:       return 8'hDF;
      2:       return 8'h8F;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic put_bit(input logic b, input logic v);
    bit_in  = b;
    bit_vld = v;
    @(posedge clk);
    #1;
  endtask

  task automatic send_frame(input int k);
    logic [7:0] ts = ts0_of(k);
    for (int b = 0; b < 256; b++) put_bit((b < 8) ? ts[7-b] : 1'b1, 1'b1);
    bit_vld = 1'b0;
  endtask

  task automatic do_reset(input logic a, input logic c);
    alg_sel = a;
    chk_en  = c;
    rst     = 1'b1;
    bit_vld = 1'b0;
    bit_in  = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int bad_fs, bad_pos, held;
    logic [7:0] keep;
    logic [7:0] ts;

    // R12: reset state
    do_reset(1'b0, 1'b0);
    check("R12 in_frame", in_frame, 0);
    check("R12 frame_start", frame_start, 0);
    check("R12 bit_pos", bit_pos, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      do_reset(VECS[v].alg, VECS[v].chk);
      for (int f = 0; f < 12; f++) begin
        send_frame(int'(VECS[v].seq[47-4*f -: 4]));
        check($sformatf("%s vec%0d frame%0d", vec_tag(v), v, f),
              in_frame, int'(VECS[v].exp[11-f]));
      end
    end

    // R10: strobe and position once locked
    do_reset(1'b0, 1'b0);
    send_frame(0); send_frame(1); send_frame(0);
    bad_fs = 0; bad_pos = 0;
    for (int fr = 0; fr < 2; fr++) begin
      ts = ts0_of(fr == 0 ? 1 : 0);
      for (int b = 0; b < 256; b++) begin
        put_bit((b < 8) ? ts[7-b] : 1'b1, 1'b1);
        if (frame_start !== (b == 0)) bad_fs++;
        if (bit_pos != b) bad_pos++;
      end
    end
    bit_vld = 1'b0;
    check("R10 frame_start misplaced", bad_fs, 0);
    check("R10 bit_pos mismatches", bad_pos, 0);

    // R12: reset while locked
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    check("R12 in_frame after reset", in_frame, 0);
    check("R12 bit_pos after reset", bit_pos, 0);

    // R11: idle cycles inside frames
    do_reset(1'b0, 1'b0);
    held = 0;
    for (int fr = 0; fr < 3; fr++) begin
      ts = ts0_of(fr == 1 ? 1 : 0);
      for (int b = 0; b < 256; b++) begin
        put_bit((b < 8) ? ts[7-b] : 1'b1, 1'b1);
        if (b % 64 == 5) begin
          keep = bit_pos;
          for (int g = 0; g < 3; g++) begin
            put_bit(1'b0, 1'b0);
            if (bit_pos != keep || frame_start) held++;
          end
        end
      end
    end
    bit_vld = 1'b0;
    check("R11 idle changed state", held, 0);
    check("R11 lock with gaps", in_frame, 1);

    // R8: policy change during checking ignored
    do_reset(1'b0, 1'b0);
    send_frame(0);
    alg_sel = 1'b1;
    send_frame(2); send_frame(0); send_frame(1);
    check("R8 alg change frame3", in_frame, 0);
    send_frame(0);
    check("R8 alg change frame4", in_frame, 1);

    // R8: confirmation enable change during checking ignored
    do_reset(1'b0, 1'b0);
    send_frame(0);
    chk_en = 1'b1;
    send_frame(1); send_frame(0);
    check("R8 chk change", in_frame, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule